// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This block is a memory-mapped timer with two independent down-counting channels behind a simple word-wide register bus. Every channel holds a control/status word, a live count and two reload words. A single write that sets both the start bit and the run bit copies reload word 1 into the count and starts the channel. From then on the count drops by one on every prescaled tick. The prescaler divides the clock by two by default.

When the count is zero and a tick arrives, the channel raises a sticky underflow flag. What it does next depends on the reload bit. With reload set, the count is reloaded from reload word 1 and the channel keeps running, which gives a periodic timer. With reload clear, the channel stops at zero, which gives a one-shot. Each channel drives its own interrupt line. The line is high while the underflow flag and the interrupt-enable bit are both set. Software clears the flag by writing the control word back with the flag bit at zero.

Bus reads are combinational from the registers. Writes take effect at the clock edge that samples them. A channel occupies a 16-byte window: channel 0 starts at 0x00 and channel 1 at 0x10.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register of both channels reads 0 and both interrupt lines are low.
- R2: Inside a channel window, the word at +0x0 is control/status, +0x4 is the count, +0x8 is reload word 1 and +0xC is reload word 2. Channel 0 sits at 0x00 and channel 1 at 0x10. The reload words read back what was written.
- R3: Control/status bits are: bit 5 output level, bit 4 reload enable, bit 3 interrupt enable, bit 2 underflow flag, bit 1 run, bit 0 start. Bits 31..6 read 0. The start bit always reads 0.
- R4: A control write with bit 0 and bit 1 both set loads the count from reload word 1 and starts the channel. From that edge on, the count drops by one every 2 clock cycles, so n cycles later it reads R - floor(n/2).
- R5: With reload enable set, a tick that finds the count at 0 sets the underflow flag and reloads the count from reload word 1. Counting continues, so the period is 2(R+1) cycles.
- R6: With reload enable clear, a tick that finds the count at 0 sets the underflow flag and clears the run bit. The count then stays at 0.
- R7: Writing 0 to bit 2 clears the underflow flag. Writing 1 to bit 2 never sets it.
- R8: Each channel's interrupt output equals its underflow flag AND its interrupt-enable bit.
- R9: The count register can be written while the channel is idle. Reads always return the live count value.
- R10: Writing 0 to the control word stops the channel, clears its flag and drops its interrupt.
- R11: A control write with the start bit set but the run bit clear leaves the count unchanged.
- R12: Activity in one channel, writes or counting, leaves the other channel's registers and interrupt unchanged.
- R13: In a cycle that writes a channel's control or count word, that channel does not decrement, reload or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address; bits 1..0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 2 | Per-channel interrupt, bit i belongs to channel i |

## Verification
A register write is visible on the read port half a cycle after the edge that samples it. A start load appears at that same edge. The first decrement lands 2 edges later, and the flag rises 2(R+1) edges after the start edge, with the interrupt line following in that same cycle. The bench drives and samples on falling edges and counts the falling edges since each write's edge. Every expected count, flag and interrupt value is derived from that count as R - floor(n/2), modulo R+1 in periodic mode, so each check lands in the exact cycle a result is due. Reload values are swept over small ranges so that the boundaries at zero are reached and passed many times.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned BUS_W        = 32;
  localparam int unsigned CH_SPAN_BITS = 4;   // 16-byte window per channel
  localparam int unsigned WORD_LSB     = 2;

  // control/status bit positions
  localparam int unsigned B_START  = 0;
  localparam int unsigned B_RUN    = 1;
  localparam int unsigned B_UFLAG  = 2;
  localparam int unsigned B_IEN    = 3;
  localparam int unsigned B_RELOAD = 4;
  localparam int unsigned B_LEVEL  = 5;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_RLD1  = 2'd2,
    REG_RLD2  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic level;
    logic reload_en;
    logic irq_en;
    logic uflag;
    logic run;
  } ctrl_t;

  // Control word as seen on the bus; start bit always reads 0.
  function automatic logic [BUS_W-1:0] pack_ctrl(input ctrl_t c);
    logic [BUS_W-1:0] w;
    w           = '0;
    w[B_LEVEL]  = c.level;
    w[B_RELOAD] = c.reload_en;
    w[B_IEN]    = c.irq_en;
    w[B_UFLAG]  = c.uflag;
    w[B_RUN]    = c.run;
    return w;
  endfunction

  // Flag update on a software write: zero clears, one keeps.
  function automatic logic flag_after_write(input logic cur, input logic wbit);
    return cur & wbit;
  endfunction

  // Start requires both the start and run bits in the same write.
  function automatic logic is_start(input logic [BUS_W-1:0] w);
    return w[B_START] & w[B_RUN];
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;

  assign tick = run && !restart && (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || !run) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  generate
    if (DIV >= 2) begin : g_gap_chk
      // R4: ticks never come on back-to-back cycles
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned CH_BITS = 1,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_BITS-1:0] ch_idx,
  output tmr_pkg::reg_sel_e  reg_sel,
  output logic [NUM_CH-1:0]  wr_ch
);
  import tmr_pkg::*;

  logic unused_byte_bits;
  assign unused_byte_bits = ^addr[WORD_LSB-1:0];

  assign ch_idx  = addr[ADDR_W-1:CH_SPAN_BITS];
  assign reg_sel = reg_sel_e'(addr[CH_SPAN_BITS-1:WORD_LSB]);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign wr_ch[i] = wr_en && (ch_idx == CH_BITS'(i));
    end
  endgenerate

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  tmr_pkg::reg_sel_e           reg_sel,
  input  logic [tmr_pkg::BUS_W-1:0]   wdata,
  input  tmr_pkg::reg_sel_e           rd_sel,
  output logic [tmr_pkg::BUS_W-1:0]   rdata,
  output logic                        irq
);
  import tmr_pkg::*;

  ctrl_t            ctl;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload1;
  logic [CNT_W-1:0] reload2;

  // named internal events
  logic ctrl_wr, cnt_wr, rld1_wr, rld2_wr;
  logic start_ld, tick, step_ok, uf_event, at_zero;

  assign ctrl_wr  = wr_en && (reg_sel == REG_CTRL);
  assign cnt_wr   = wr_en && (reg_sel == REG_COUNT);
  assign rld1_wr  = wr_en && (reg_sel == REG_RLD1);
  assign rld2_wr  = wr_en && (reg_sel == REG_RLD2);
  assign start_ld = ctrl_wr && is_start(wdata);
  assign at_zero  = (count == '0);
  assign step_ok  = tick && !ctrl_wr && !cnt_wr;
  assign uf_event = step_ok && at_zero;

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl.run),
    .restart (start_ld),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      count <= '0;
    end else if (ctrl_wr) begin
      ctl.level     <= wdata[B_LEVEL];
      ctl.reload_en <= wdata[B_RELOAD];
      ctl.irq_en    <= wdata[B_IEN];
      ctl.run       <= wdata[B_RUN];
      ctl.uflag     <= flag_after_write(ctl.uflag, wdata[B_UFLAG]);
      if (start_ld) count <= reload1;
    end else if (cnt_wr) begin
      count <= wdata[CNT_W-1:0];
    end else if (step_ok) begin
      if (at_zero) begin
        ctl.uflag <= 1'b1;
        if (ctl.reload_en) count <= reload1;
        else               ctl.run <= 1'b0;
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload1 <= '0;
      reload2 <= '0;
    end else begin
      if (rld1_wr) reload1 <= wdata[CNT_W-1:0];
      if (rld2_wr) reload2 <= wdata[CNT_W-1:0];
    end
  end

  assign irq = ctl.uflag & ctl.irq_en;

  always_comb begin
    unique case (rd_sel)
      REG_CTRL:  rdata = pack_ctrl(ctl);
      REG_COUNT: rdata = BUS_W'(count);
      REG_RLD1:  rdata = BUS_W'(reload1);
      REG_RLD2:  rdata = BUS_W'(reload2);
      default:   rdata = '0;
    endcase
  end

  // R4: start loads reload word 1 and runs
  p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_ld |=> (count == $past(reload1)) && ctl.run);
  // R4: a tick on a nonzero count decrements by one
  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !at_zero) |=> (count == $past(count) - CNT_W'(1)));
  // R5: periodic underflow sets flag and reloads
  p_periodic_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && ctl.reload_en) |=> ctl.uflag && ctl.run && (count == $past(reload1)));
  // R6: one-shot underflow halts at zero
  p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && !ctl.reload_en) |=> ctl.uflag && !ctl.run && (count == '0));
  // R6: an idle channel keeps its count
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !ctrl_wr && !cnt_wr) |=> $stable(count));
  // R7: software cannot set the flag
  p_no_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctl.uflag) |=> !ctl.uflag);
  // R10: writing zero silences the channel
  p_zero_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (wdata == '0)) |=> !irq && !ctl.run);
  // R13: count write overrides counting
  p_count_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wdata[CNT_W-1:0])));

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PRESCALE = 2,
  localparam int unsigned CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W  = CH_BITS + tmr_pkg::CH_SPAN_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [tmr_pkg::BUS_W-1:0] bus_wdata,
  output logic [tmr_pkg::BUS_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0]         irq
);
  import tmr_pkg::*;

  logic [CH_BITS-1:0] ch_idx;
  reg_sel_e           reg_sel;
  logic [NUM_CH-1:0]  wr_ch;
  logic [BUS_W-1:0]   ch_rdata [NUM_CH];

  tmr_bus_decode #(
    .NUM_CH (NUM_CH),
    .CH_BITS(CH_BITS),
    .ADDR_W (ADDR_W)
  ) u_dec (
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .ch_idx (ch_idx),
    .reg_sel(reg_sel),
    .wr_ch  (wr_ch)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_channel #(
        .CNT_W(CNT_W),
        .DIV  (PRESCALE)
      ) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ch[i]),
        .reg_sel(reg_sel),
        .wdata  (bus_wdata),
        .rd_sel (reg_sel),
        .rdata  (ch_rdata[i]),
        .irq    (irq[i])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CH_BITS'(i)) bus_rdata = ch_rdata[i];
    end
  end

  // R12: a write targets at most one channel
  p_single_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_ch));

endmodule

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;

  localparam int CT_LVL = 32'h20, CT_RLD = 32'h10, CT_IEN = 32'h08;
  localparam int CT_UF = 32'h04, CT_RUN = 32'h02, CT_STR = 32'h01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  dual_down_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {30'h0, irq}, 32'h0);

    // R2: reload words per channel
    wr(5'h08, 32'hA5A5_0001); wr(5'h0C, 32'h1234_5678);
    wr(5'h18, 32'h0F0F_0002); wr(5'h1C, 32'hDEAD_BEEF);
    rd(5'h08, v); chk("R2 ch0 reload1", v, 32'hA5A5_0001);
    rd(5'h0C, v); chk("R2 ch0 reload2", v, 32'h1234_5678);
    rd(5'h18, v); chk("R2 ch1 reload1", v, 32'h0F0F_0002);
    rd(5'h1C, v); chk("R2 ch1 reload2", v, 32'hDEAD_BEEF);

    // R3: upper bits ignored, bits readable
    wr(5'h00, 32'hFFFF_FFC0 | CT_LVL | CT_RLD | CT_IEN);
    rd(5'h00, v); chk("R3 ctrl readback", v, CT_LVL | CT_RLD | CT_IEN);
    wr(5'h00, 32'h0);

    // R9 / R11: idle count write, start without run
    wr(5'h04, 32'h55);
    rd(5'h04, v); chk("R9 count write idle", v, 32'h55);
    wr(5'h08, 32'h7);
    wr(5'h00, CT_STR);
    rd(5'h04, v); chk("R11 start w/o run keeps count", v, 32'h55);
    rd(5'h00, v); chk("R3 start reads zero", v, 32'h0);

    // R4 / R6: one-shot sweep on channel 0
    for (int r = 0; r < 7; r += 3) begin
      wr(5'h08, 32'(r));
      wr(5'h00, CT_RUN | CT_STR);
      for (int n = 0; n <= 2 * r + 6; n++) begin
        int t;
        t = n / 2;
        rd(5'h04, v);
        chk(t <= r ? "R4 oneshot count" : "R6 oneshot hold", v, t <= r ? 32'(r - t) : 32'h0);
        rd(5'h00, v);
        chk(t <= r ? "R3 running ctrl" : "R6 stopped ctrl", v, t <= r ? CT_RUN : CT_UF);
        chk("R8 irq masked", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
      end
      // R7: write 1 keeps, 0 clears, 1 never sets
      wr(5'h00, CT_UF);
      rd(5'h00, v); chk("R7 write one keeps flag", v, CT_UF);
      wr(5'h00, 32'h0);
      rd(5'h00, v); chk("R7 write zero clears", v, 32'h0);
      wr(5'h00, CT_UF);
      rd(5'h00, v); chk("R7 write one no set", v, 32'h0);
    end

    // R5 / R8 / R12: periodic sweep on channel 1
    for (int r = 0; r < 5; r++) begin
      logic [31:0] c1;
      wr(5'h18, 32'(r));
      wr(5'h10, CT_RLD | CT_IEN | CT_RUN | CT_STR);
      for (int n = 0; n <= 4 * (r + 1) + 1; n++) begin
        int t;
        bit f;
        t = n / 2;
        f = (t >= r + 1);
        rd(5'h14, v);
        chk("R5 periodic count", v, 32'(r - (t % (r + 1))));
        rd(5'h10, v);
        chk("R5 periodic flag", v, CT_RLD | CT_IEN | CT_RUN | (f ? CT_UF : 0));
        chk("R8 irq follows flag", {30'h0, irq}, {30'h0, f, 1'b0});
        @(negedge clk);
      end
      rd(5'h04, v); chk("R12 ch0 count untouched", v, 32'h0);
      rd(5'h00, v); chk("R12 ch0 ctrl untouched", v, 32'h0);
      // R7 / R8: clearing flag drops irq while running
      wr(5'h10, CT_RLD | CT_IEN | CT_RUN);
      rd(5'h10, v); chk("R7 clear while running", v, CT_RLD | CT_IEN | CT_RUN);
      chk("R8 irq drops", {30'h0, irq}, 32'h0);
      // R10: write zero stops
      repeat (2 * (r + 1) + 1) @(negedge clk);
      chk("R8 irq rises again", {30'h0, irq}, 32'h2);
      wr(5'h10, 32'h0);
      rd(5'h14, c1);
      chk("R10 irq cleared", {30'h0, irq}, 32'h0);
      rd(5'h10, v); chk("R10 ctrl cleared", v, 32'h0);
      repeat (6) @(negedge clk);
      rd(5'h14, v); chk("R10 count frozen", v, c1);
    end

    // R13: count write while running wins over that cycle's step
    wr(5'h18, 32'd20);
    wr(5'h10, CT_RUN | CT_STR);
    @(negedge clk);
    wr(5'h14, 32'd9);
    rd(5'h14, v); chk("R13 count write wins", v, 32'd9);
    wr(5'h10, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule